// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block picks, in every cycle, at most one of the warps resident on a compute core to issue its next instruction. A warp is a group of 32 threads that run in lockstep, and the scheduler works only at that granularity. Each warp is either ready or stalled. Only a warp that presents a valid instruction and is not stalled may be chosen.

When the chosen warp's next instruction is a long-latency memory load, the warp is parked at once. It does not wait for the data. Because of that, the issue slot goes to some other ready warp in the very next cycle, and the load's latency is covered by the other warps' work. A parked warp becomes eligible again only when a memory response tagged with its warp ID comes back. Arithmetic instructions leave a warp's state unchanged. Among the ready warps, the choice is round-robin, starting just after the warp that issued last. The issue outputs are combinational from the current state and inputs. Park and wake-up updates take effect from the next clock edge.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is stalled and the round-robin pointer sits on the last warp, so the first issue goes to the lowest-numbered valid warp.
- R2: In any cycle at most one warp issues, and the warp named on issueWarpId is valid and not stalled.
- R3: When the issued warp's instruction type bit warpIsLoad is 1 (long-latency load), that warp is stalled from the next cycle on and is not issued again until it is woken.
- R4: Whenever at least one warp is valid and not stalled, issueValid is high in that cycle, so a warp that has just parked is followed at once by another ready warp.
- R5: A response with respValid high and respWarpId equal to a stalled warp's index makes that warp ready from the next cycle. A response for a warp that is not stalled has no effect.
- R6: Among the eligible warps, the scheduler picks the first one found scanning upward, with wrap-around, from the index after the warp that issued last. The pointer does not move in a cycle with no issue.
- R7: When no warp is both valid and not stalled, issueValid is low and issueWarpId is 0.
- R8: Issuing an instruction with warpIsLoad 0 (arithmetic) does not change any warp's ready or stalled state.
- R9: When a load issues for a warp in the same cycle as a response tagged with that warp's ID, the warp ends up stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| warpValid | input | NUM_WARPS | Per warp: an instruction is waiting to issue |
| warpIsLoad | input | NUM_WARPS | Per warp: 1 = next instruction is a long-latency load, 0 = arithmetic |
| respValid | input | 1 | A memory response arrives this cycle |
| respWarpId | input | $clog2(NUM_WARPS) | Warp the response belongs to |
| issueValid | output | 1 | A warp issues this cycle |
| issueWarpId | output | $clog2(NUM_WARPS) | Index of the issuing warp, 0 when none |

## Verification
The first directed pattern holds all warps valid with arithmetic instructions. This shows the rotation order and shows that nothing ever parks. In the second, every warp issues a load, so the warps park one after another until the block goes idle. This separates parking at issue from parking on a later cycle, and it exposes any idle gap between two ready warps. Responses are then sent in a scrambled order, along with stray responses for warps that are not parked and a response that coincides with a load issue for the same warp. These tell apart a correct wake-up from no wake-up, from a wake-up of the wrong warp, and from a set-versus-clear priority that is wrong. Long random runs with sparse, medium and dense valid masks and load mixes then compare every cycle's pick against a bench model of the rotation.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // Strobes from the selection control to the state datapath.
  typedef struct packed {
    logic fire;   // a warp issues this cycle
    logic park;   // the issued instruction is a long-latency load
  } wis_strobe_t;

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] reqMask,
  input  logic [WID_W-1:0]     lastPtr,
  output logic                 anyReq,
  output logic [WID_W-1:0]     pickId
);

  // Scan upward from lastPtr+1 with wrap-around; the first set bit wins.
  always_comb begin
    int idx;
    anyReq = 1'b0;
    pickId = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      idx = 32'(lastPtr) + 1 + i;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!anyReq && reqMask[idx]) begin
        anyReq = 1'b1;
        pickId = idx[WID_W-1:0];
      end
    end
  end

endmodule

// File: rtl/wis_ctrl.sv
module wis_ctrl
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] warpValid,
  input  logic [NUM_WARPS-1:0] warpIsLoad,
  input  logic [NUM_WARPS-1:0] stallVec,
  input  logic [WID_W-1:0]     lastPtr,
  output wis_strobe_t          strobe,
  output logic [WID_W-1:0]     issueId
);

  logic [NUM_WARPS-1:0] eligible;
  logic                 anyReady;
  logic [WID_W-1:0]     pickId;

  assign eligible = warpValid & ~stallVec;

  wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .reqMask (eligible),
    .lastPtr (lastPtr),
    .anyReq  (anyReady),
    .pickId  (pickId)
  );

  always_comb begin
    strobe.fire = anyReady;
    strobe.park = anyReady & warpIsLoad[pickId];
    issueId     = anyReady ? pickId : '0;
  end

endmodule

// File: rtl/wis_datapath.sv
module wis_datapath
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wis_strobe_t          strobe,
  input  logic [WID_W-1:0]     issueId,
  input  logic                 respValid,
  input  logic [WID_W-1:0]     respWarpId,
  output logic [NUM_WARPS-1:0] stallVec,
  output logic [WID_W-1:0]     lastPtr
);

  logic [NUM_WARPS-1:0] nextStall;
  logic                 respInRange;

  assign respInRange = respValid && (32'(respWarpId) < NUM_WARPS);

  // Wake first, then park: a load issued together with a response for the
  // same warp leaves it stalled.
  always_comb begin
    nextStall = stallVec;
    if (respInRange) nextStall[respWarpId] = 1'b0;
    if (strobe.park) nextStall[issueId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallVec <= '0;
      lastPtr  <= WID_W'(NUM_WARPS - 1);
    end else begin
      stallVec <= nextStall;
      if (strobe.fire) lastPtr <= issueId;
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] warpValid,
  input  logic [NUM_WARPS-1:0] warpIsLoad,
  input  logic                 respValid,
  input  logic [WID_W-1:0]     respWarpId,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarpId
);

  wis_strobe_t          strobe;
  logic [WID_W-1:0]     issueId;
  logic [NUM_WARPS-1:0] stallVec;
  logic [WID_W-1:0]     lastPtr;

  wis_ctrl #(.NUM_WARPS(NUM_WARPS)) u_ctrl (
    .warpValid  (warpValid),
    .warpIsLoad (warpIsLoad),
    .stallVec   (stallVec),
    .lastPtr    (lastPtr),
    .strobe     (strobe),
    .issueId    (issueId)
  );

  wis_datapath #(.NUM_WARPS(NUM_WARPS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .issueId    (issueId),
    .respValid  (respValid),
    .respWarpId (respWarpId),
    .stallVec   (stallVec),
    .lastPtr    (lastPtr)
  );

  assign issueValid  = strobe.fire;
  assign issueWarpId = issueId;

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_WARPS-1:0] warpValid,
  input logic [NUM_WARPS-1:0] warpIsLoad,
  input logic                 respValid,
  input logic [WID_W-1:0]     respWarpId,
  input logic                 issueValid,
  input logic [WID_W-1:0]     issueWarpId,
  input logic [NUM_WARPS-1:0] stallVec
);

  logic anyEligible;
  assign anyEligible = |(warpValid & ~stallVec);

  p_issue_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (warpValid[issueWarpId] && !stallVec[issueWarpId]));

  p_load_parks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && warpIsLoad[issueWarpId]) |=> stallVec[$past(issueWarpId)]);

  p_no_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    anyEligible |-> issueValid);

  p_resp_wakes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && stallVec[respWarpId]) |=> !stallVec[$past(respWarpId)]);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !anyEligible |-> (!issueValid && issueWarpId == '0));

  p_arith_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !warpIsLoad[issueWarpId]) |=> !stallVec[$past(issueWarpId)]);

  p_park_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && warpIsLoad[issueWarpId] && respValid && respWarpId == issueWarpId)
      |=> stallVec[$past(issueWarpId)]);

endmodule

bind warp_issue_sched wis_checker #(.NUM_WARPS(NUM_WARPS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .warpValid   (warpValid),
  .warpIsLoad  (warpIsLoad),
  .respValid   (respValid),
  .respWarpId  (respWarpId),
  .issueValid  (issueValid),
  .issueWarpId (issueWarpId),
  .stallVec    (stallVec)
);

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;

  localparam int N = 8;
  localparam int W = $clog2(N);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] warpValid = '0;
  logic [N-1:0] warpIsLoad = '0;
  logic         respValid = 1'b0;
  logic [W-1:0] respWarpId = '0;
  logic         issueValid;
  logic [W-1:0] issueWarpId;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model state
  logic [N-1:0] mStall;
  int           mLast;

  always #4 clk = ~clk;   // 125 MHz

  warp_issue_sched #(.NUM_WARPS(N)) dut (
    .clk(clk), .rstN(rstN), .warpValid(warpValid), .warpIsLoad(warpIsLoad),
    .respValid(respValid), .respWarpId(respWarpId),
    .issueValid(issueValid), .issueWarpId(issueWarpId)
  );

  function automatic int expPick(logic [N-1:0] elig, int last);
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (last + i) % N;
      if (elig[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check combinational outputs,
  // then advance the model to match the next rising edge.
  task automatic step(logic [N-1:0] v, logic [N-1:0] ld, logic rv, int rid, string tag);
    int e;
    @(negedge clk);
    warpValid = v; warpIsLoad = ld; respValid = rv; respWarpId = W'(rid);
    #1;
    e = expPick(v & ~mStall, mLast);
    check(tag, int'(issueValid), (e >= 0) ? 1 : 0, "issueValid");
    check(tag, int'(issueWarpId), (e >= 0) ? e : 0, "issueWarpId");
    if (rv) mStall[rid] = 1'b0;
    if (e >= 0) begin
      if (ld[e]) mStall[e] = 1'b1;
      mLast = e;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] allOnes;
    allOnes = '1;
    void'($urandom(32'd20240611));
    mStall = '0;
    mLast = N - 1;
    repeat (3) @(posedge clk);
    #1;
    check("R7", int'(issueValid), 0, "issueValid in reset");
    @(negedge clk);
    rstN = 1'b1;

    // R1 first pick is warp 0; R6 rotation; R8 arithmetic never parks
    for (int c = 0; c < 2 * N; c++) step(allOnes, '0, 1'b0, 0, (c == 0) ? "R1" : "R8");
    // R6 sparse mask skips invalid warps
    for (int c = 0; c < 6; c++) step(8'b1010_0100, '0, 1'b0, 0, "R6");
    // R3/R4 every warp loads: park one per cycle, no idle gap
    for (int c = 0; c < N; c++) step(allOnes, allOnes, 1'b0, 0, "R4");
    // R7 all parked: idle
    for (int c = 0; c < 3; c++) step(allOnes, allOnes, 1'b0, 0, "R7");
    // R5 wake warp 5, then warp 2; R3 they park again
    step(allOnes, allOnes, 1'b1, 5, "R5");
    step(allOnes, allOnes, 1'b1, 2, "R5");
    step(allOnes, allOnes, 1'b0, 0, "R3");
    // R9 warp 2 wake, then its load coincides with another response for it
    step(allOnes, '0, 1'b1, 2, "R5");
    step(allOnes, allOnes, 1'b1, 2, "R9");
    step(allOnes, allOnes, 1'b0, 0, "R9");
    // wake all, then stray responses for non-parked warps (R5 no effect)
    for (int w = 0; w < N; w++) step('0, '0, 1'b1, (w * 3) % N, "R5");
    for (int c = 0; c < 4; c++) step(8'b0001_0001, '0, 1'b1, 0, "R5");
    step(8'b0001_0001, '0, 1'b1, 4, "R5");

    // Random phases: sparse, medium, dense
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 3000; c++) begin
        logic [N-1:0] v, ld;
        logic rv;
        int rid;
        v = N'($urandom);
        if (ph == 0) v = v & N'($urandom) & N'($urandom);
        if (ph == 2) v = v | N'($urandom);
        ld = N'($urandom) & N'($urandom);
        rv = ($urandom % 3) == 0;
        rid = $urandom % N;
        step(v, ld, rv, rid, (ph == 1) ? "R6" : "R2");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule